// File: doc/BRIEF.md
# Loss-of-Signal Detector

This block raises the receive loss-of-signal alarm for a line receiver. It runs in one of two modes, picked by a mode input. In zero-density mode it watches the recovered bit stream. A long run of zeros raises the alarm. The alarm drops only once a sliding window of recent bits carries enough ones and holds no long zero run. In level-qualification mode it ignores the data. Instead it times the two flags from an analog peak comparator, one meaning "below the set threshold" and one meaning "above the clear threshold", in bit periods. The set and clear thresholds differ, which gives hysteresis in both modes.

While the alarm is high, the block tells the datapath to force the received data low and to run the output clock from the reference clock. In zero-density mode, a below-threshold comparator flag also forces the data low on its own, without raising the alarm. All window lengths and thresholds are parameters. By default the zero-density mode sets on 175 zeros and clears on 58 ones in 175 bits with no run of 100 zeros. By default the level mode sets after 128 bits below threshold and clears after 32 bits above it.

Top module: `los_sig_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `los_alarm`, `squelch` and `clk_sel_ref` are 1 after that edge. The alarm stays 1 after reset until a clear condition is met.
- R2: In zero-density mode (`mode_e3`=0), the alarm is 1 after the edge that samples the SET_ZEROS-th consecutive 0 on `rx_data`. A 1 restarts the run count.
- R3: In zero-density mode, a high alarm drops at the edge where three things hold: the last WIN_LEN sampled bits hold at least MIN_ONES ones, none of those bits ends a zero run of MAX_ZRUN or more, and at least WIN_LEN bits have been sampled since reset or the last mode change. Otherwise the alarm holds.
- R4: In zero-density mode, `squelch` is 1 whenever `lvl_below` is 1, even with the alarm low. `lvl_below` and `lvl_above` never change the alarm in this mode.
- R5: In level mode (`mode_e3`=1), the alarm is 1 after the edge that samples `lvl_below`=1 for the E3_SET-th consecutive time. A 0 restarts that count.
- R6: In level mode, a high alarm drops at the edge that samples `lvl_above`=1 for the E3_CLR-th consecutive time, unless the set condition also holds at that edge. `rx_data` has no effect in this mode.
- R7: `clk_sel_ref` equals the alarm. In level mode `squelch` equals the alarm, and in every mode `squelch` is 1 while the alarm is 1.
- R8: An edge at which `mode_e3` differs from its value at the previous edge leaves the alarm unchanged. That edge restarts every count and empties the bit window, and the inputs at that edge are discarded.
- R9: Zero-run and level counts saturate rather than wrap. An arbitrarily long zero run or below-threshold stretch keeps the alarm high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Recovered data bit, one per clock |
| lvl_below | input | 1 | Comparator flag: peak level below the set threshold |
| lvl_above | input | 1 | Comparator flag: peak level above the clear threshold |
| mode_e3 | input | 1 | 0 = zero-density mode, 1 = level-qualification mode |
| los_alarm | output | 1 | Loss-of-signal alarm |
| squelch | output | 1 | Force the received data outputs low |
| clk_sel_ref | output | 1 | Select the reference clock for the output clock |

## Verification
The bench builds the block with a 12-bit window, a set run of 10 zeros, a clear floor of 4 ones, a forbidden zero run of 6, and level counts of 8 and 3. With these values, every threshold, the sliding window and the saturation of the counters are reached within tens of bits. Many set/clear cycles, mode switches and exact off-by-one boundaries then fit into a short run. A bit-history model in the bench recomputes the ones count and the longest run in the window directly from the stimulus, cycle by cycle.

// File: rtl/los_pkg.sv
// Shared types for the loss-of-signal detector.
package los_pkg;
    // Detection mode as carried on the mode select input.
    typedef enum logic {
        MODE_ZERO_DENSITY = 1'b0,
        MODE_LEVEL_QUAL   = 1'b1
    } los_mode_e;

    // Verdict a qualifier hands to the alarm register each bit.
    typedef struct packed {
        logic set_hit;
        logic clr_ok;
    } los_verdict_t;
endpackage

// File: rtl/los_ones_window.sv
// Sliding ones count over the last WIN_LEN bits.
// Assumes one bit per clock; flush empties the window (all zeros).
// ones_nx is the count including the bit presented this cycle.
module los_ones_window #(
    parameter int WIN_LEN = 175,
    localparam int OW = $clog2(WIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          din,
    output logic [OW-1:0] ones_nx
);
    logic [WIN_LEN-1:0] taps;
    logic [OW-1:0]      ones_q;

    // Count after the new bit enters and the oldest leaves.
    assign ones_nx = ones_q + OW'(din) - OW'(taps[WIN_LEN-1]);

    // Bit history: the variant depends on the window length.
    if (WIN_LEN == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (!rst_n || flush) taps <= '0;
            else                 taps <= din;
        end
    end else begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n || flush) taps <= '0;
            else                 taps <= {taps[WIN_LEN-2:0], din};
        end
    end

    // Running ones count tracks the history register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) ones_q <= '0;
        else                 ones_q <= ones_nx;
    end
endmodule

// File: rtl/los_run_counter.sv
// Saturating count of consecutive cycles with flag high.
// hit is high in the cycle whose flag completes LIMIT consecutive highs
// (and stays high while the run continues).
module los_run_counter #(
    parameter int LIMIT = 128,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic flag,
    output logic hit
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    logic [CW-1:0] cnt_q, cnt_nx;

    // Next count: restart on a low flag, hold at the limit.
    always_comb begin
        if (!flag)            cnt_nx = '0;
        else if (cnt_q == LIM) cnt_nx = LIM;
        else                  cnt_nx = cnt_q + 1'b1;
    end

    assign hit = (cnt_nx == LIM);

    // Run count register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cnt_q <= '0;
        else                 cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/los_ds3_qual.sv
// Zero-density qualifier: sets on a long zero run, allows clearing when
// the window has enough ones, no long zero run ended inside it, and at
// least one full window has been seen since the last flush.
// Assumes flush is held while the other mode is active.
module los_ds3_qual
    import los_pkg::*;
#(
    parameter int WIN_LEN   = 175,
    parameter int SET_ZEROS = 175,
    parameter int MIN_ONES  = 58,
    parameter int MAX_ZRUN  = 100,
    localparam int ZCAP = (SET_ZEROS > MAX_ZRUN) ? SET_ZEROS : MAX_ZRUN,
    localparam int ZW   = $clog2(ZCAP + 1),
    localparam int QW   = $clog2(WIN_LEN + 1),
    localparam int OW   = $clog2(WIN_LEN + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         din,
    output los_verdict_t verdict
);
    localparam logic [ZW-1:0] ZCAP_L  = ZW'(ZCAP);
    localparam logic [ZW-1:0] SET_L   = ZW'(SET_ZEROS);
    localparam logic [ZW-1:0] LONG_L  = ZW'(MAX_ZRUN);
    localparam logic [QW-1:0] WIN_L   = QW'(WIN_LEN);
    localparam logic [OW-1:0] MINO_L  = OW'(MIN_ONES);

    logic [ZW-1:0] zrun_q, zrun_nx;
    logic [QW-1:0] quiet_q, quiet_nx;
    logic [OW-1:0] ones_nx;
    logic          long_end;

    los_ones_window #(.WIN_LEN(WIN_LEN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .din     (din),
        .ones_nx (ones_nx)
    );

    // Zero run including this bit, saturating at ZCAP.
    always_comb begin
        if (din)                 zrun_nx = '0;
        else if (zrun_q == ZCAP_L) zrun_nx = ZCAP_L;
        else                     zrun_nx = zrun_q + 1'b1;
    end

    assign long_end = !din && (zrun_nx >= LONG_L);

    // Bits since the last bit that ended a long zero run, saturating.
    always_comb begin
        if (long_end)           quiet_nx = '0;
        else if (quiet_q == WIN_L) quiet_nx = WIN_L;
        else                    quiet_nx = quiet_q + 1'b1;
    end

    // Verdict for the alarm register.
    always_comb begin
        verdict.set_hit = !flush && (zrun_nx >= SET_L);
        verdict.clr_ok  = !flush && (ones_nx >= MINO_L) && (quiet_nx >= WIN_L);
    end

    // Run and quiet counters.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            zrun_q  <= '0;
            quiet_q <= '0;
        end else begin
            zrun_q  <= zrun_nx;
            quiet_q <= quiet_nx;
        end
    end
endmodule

// File: rtl/los_e3_qual.sv
// Level qualifier: sets after E3_SET consecutive below-threshold bits,
// allows clearing after E3_CLR consecutive above-threshold bits.
// Assumes flush is held while the other mode is active.
module los_e3_qual
    import los_pkg::*;
#(
    parameter int E3_SET = 128,
    parameter int E3_CLR = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         lvl_below,
    input  logic         lvl_above,
    output los_verdict_t verdict
);
    logic below_hit, above_hit;

    los_run_counter #(.LIMIT(E3_SET)) u_below (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .flag  (lvl_below),
        .hit   (below_hit)
    );

    los_run_counter #(.LIMIT(E3_CLR)) u_above (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .flag  (lvl_above),
        .hit   (above_hit)
    );

    // Gate both verdicts off while flushed.
    always_comb begin
        verdict.set_hit = !flush && below_hit;
        verdict.clr_ok  = !flush && above_hit;
    end
endmodule

// File: rtl/los_sig_monitor.sv
// Loss-of-signal detector top. Holds the alarm register and the mode
// history; picks the active qualifier and drives squelch and clock select.
// Assumes one recovered bit and one comparator sample per clock.
module los_sig_monitor
    import los_pkg::*;
#(
    parameter int WIN_LEN   = 175,
    parameter int SET_ZEROS = 175,
    parameter int MIN_ONES  = 58,
    parameter int MAX_ZRUN  = 100,
    parameter int E3_SET    = 128,
    parameter int E3_CLR    = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data,
    input  logic lvl_below,
    input  logic lvl_above,
    input  logic mode_e3,
    output logic los_alarm,
    output logic squelch,
    output logic clk_sel_ref
);
    los_mode_e    mode_now, mode_q;
    logic         mode_chg;
    logic         zd_flush, lq_flush;
    los_verdict_t zd_v, lq_v;
    logic         alarm_q;
    logic         set_any, clr_any;

    assign mode_now = los_mode_e'(mode_e3);
    assign mode_chg = (mode_now != mode_q);
    assign zd_flush = mode_chg || (mode_now != MODE_ZERO_DENSITY);
    assign lq_flush = mode_chg || (mode_now != MODE_LEVEL_QUAL);

    // Mode seen at the previous edge, for change detection.
    always_ff @(posedge clk) begin
        mode_q <= mode_now;
    end

    los_ds3_qual #(
        .WIN_LEN   (WIN_LEN),
        .SET_ZEROS (SET_ZEROS),
        .MIN_ONES  (MIN_ONES),
        .MAX_ZRUN  (MAX_ZRUN)
    ) u_zd (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (zd_flush),
        .din     (rx_data),
        .verdict (zd_v)
    );

    los_e3_qual #(
        .E3_SET (E3_SET),
        .E3_CLR (E3_CLR)
    ) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (lq_flush),
        .lvl_below (lvl_below),
        .lvl_above (lvl_above),
        .verdict   (lq_v)
    );

    // Only the unflushed qualifier can report; the other reads zero.
    assign set_any = zd_v.set_hit | lq_v.set_hit;
    assign clr_any = zd_v.clr_ok  | lq_v.clr_ok;

    // Alarm register: set wins over clear, mode-change edges hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             alarm_q <= 1'b1;
        else if (!mode_chg) begin
            if (set_any)        alarm_q <= 1'b1;
            else if (clr_any)   alarm_q <= 1'b0;
        end
    end

    // Output drive: squelch also follows the below flag in zero-density mode.
    always_comb begin
        los_alarm   = alarm_q;
        clk_sel_ref = alarm_q;
        squelch     = alarm_q || ((mode_now == MODE_ZERO_DENSITY) && lvl_below);
    end
endmodule

// File: rtl/los_sig_monitor_chk.sv
// Property checker for the loss-of-signal detector, bound to the top.
// Keeps its own run counters, independent of the design's.
module los_sig_monitor_chk #(
    parameter int SET_ZEROS = 175,
    parameter int E3_SET    = 128,
    localparam int ZW = $clog2(SET_ZEROS + 1),
    localparam int BW = $clog2(E3_SET + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic rx_data,
    input logic lvl_below,
    input logic lvl_above,
    input logic mode_e3,
    input logic los_alarm,
    input logic squelch,
    input logic clk_sel_ref
);
    localparam logic [ZW-1:0] ZSET = ZW'(SET_ZEROS);
    localparam logic [BW-1:0] BSET = BW'(E3_SET);
    logic          mq;
    logic [ZW-1:0] zc;
    logic [BW-1:0] bc;

    // Previous mode and independent run counts.
    always_ff @(posedge clk) begin
        mq <= mode_e3;
        if (!rst_n || mode_e3 != mq || mode_e3 || rx_data) zc <= '0;
        else if (zc != ZSET)                              zc <= zc + 1'b1;
        if (!rst_n || mode_e3 != mq || !mode_e3 || !lvl_below) bc <= '0;
        else if (bc != BSET)                                  bc <= bc + 1'b1;
    end

    // R1: reset forces the alarm.
    a_r1_reset_alarm: assert property (@(posedge clk)
        !rst_n |=> los_alarm);

    // R2: the SET_ZEROS-th zero raises the alarm.
    a_r2_zero_run_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_e3 && mq == mode_e3 && !rx_data && zc >= ZSET - 1'b1) |=> los_alarm);

    // R5: the E3_SET-th below sample raises the alarm.
    a_r5_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e3 && mq == mode_e3 && lvl_below && bc >= BSET - 1'b1) |=> los_alarm);

    // R6: in level mode the alarm only drops on an above sample.
    a_r6_clear_needs_above: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(los_alarm) && mode_e3 && $past(mode_e3)) |-> $past(lvl_above));

    // R7: alarm drives squelch and reference clock select.
    a_r7_alarm_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        los_alarm |-> (squelch && clk_sel_ref));
endmodule

bind los_sig_monitor los_sig_monitor_chk #(
    .SET_ZEROS (SET_ZEROS),
    .E3_SET    (E3_SET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .lvl_below   (lvl_below),
    .lvl_above   (lvl_above),
    .mode_e3     (mode_e3),
    .los_alarm   (los_alarm),
    .squelch     (squelch),
    .clk_sel_ref (clk_sel_ref)
);

// File: tb/sim_los_sig_monitor.sv
`timescale 1ns/1ps
module sim_los_sig_monitor;
    localparam int W  = 12;
    localparam int SZ = 10;
    localparam int MO = 4;
    localparam int MZ = 6;
    localparam int ES = 8;
    localparam int EC = 3;
    localparam int HMAX = 16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data = 1'b0;
    logic lvl_below = 1'b0;
    logic lvl_above = 1'b0;
    logic mode_e3 = 1'b0;
    logic los_alarm, squelch, clk_sel_ref;

    int n_chk = 0;
    int n_fail = 0;
    bit hist [HMAX];
    int seg_len = 0;
    bit m_alarm = 1'b1;
    bit prev_mode = 1'b0;
    int brun = 0;
    int arun = 0;
    string phase_tag = "";

    always #4 clk = ~clk;

    los_sig_monitor #(
        .WIN_LEN (W), .SET_ZEROS (SZ), .MIN_ONES (MO),
        .MAX_ZRUN (MZ), .E3_SET (ES), .E3_CLR (EC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .rx_data (rx_data),
        .lvl_below (lvl_below), .lvl_above (lvl_above), .mode_e3 (mode_e3),
        .los_alarm (los_alarm), .squelch (squelch), .clk_sel_ref (clk_sel_ref)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Length of the zero run ending at index p of the current segment.
    function automatic int zrun_at(int p);
        int n = 0;
        while (p >= 0 && hist[p] == 1'b0) begin
            n++;
            p--;
        end
        return n;
    endfunction

    // One clock edge of the requirement model; returns 1 on a mode change.
    function automatic bit model_edge();
        bit chg = 1'b0;
        if (!rst_n) begin
            m_alarm = 1'b1; seg_len = 0; brun = 0; arun = 0; prev_mode = mode_e3;
        end else if (mode_e3 != prev_mode) begin
            seg_len = 0; brun = 0; arun = 0; prev_mode = mode_e3; chg = 1'b1;
        end else if (!mode_e3) begin
            int ones = 0;
            bit long_in = 1'b0;
            bit set_c, clr_c;
            if (seg_len < HMAX) begin
                hist[seg_len] = rx_data;
                seg_len++;
            end
            for (int p = seg_len - W; p < seg_len; p++) begin
                if (p >= 0) begin
                    if (hist[p]) ones++;
                    else if (zrun_at(p) >= MZ) long_in = 1'b1;
                end
            end
            set_c = zrun_at(seg_len - 1) >= SZ;
            clr_c = ones >= MO && !long_in && seg_len >= W;
            if (set_c) m_alarm = 1'b1;
            else if (m_alarm && clr_c) m_alarm = 1'b0;
        end else begin
            brun = lvl_below ? brun + 1 : 0;
            arun = lvl_above ? arun + 1 : 0;
            if (brun >= ES) m_alarm = 1'b1;
            else if (m_alarm && arun >= EC) m_alarm = 1'b0;
        end
        return chg;
    endfunction

    // Apply inputs, take one edge, compare outputs against the model.
    task automatic step(bit d, bit b, bit a, bit m);
        bit old_a, chg;
        string ta, ts;
        rx_data = d; lvl_below = b; lvl_above = a; mode_e3 = m;
        @(posedge clk);
        #1;
        old_a = m_alarm;
        chg = model_edge();
        if (!rst_n) ta = "R1";
        else if (phase_tag != "") ta = phase_tag;
        else if (chg) ta = "R8";
        else if (!mode_e3) ta = (old_a && !m_alarm) ? "R3" : "R2";
        else ta = (old_a && !m_alarm) ? "R6" : "R5";
        ts = (!rst_n) ? "R1" : (!m_alarm && !mode_e3 && lvl_below) ? "R4" : "R7";
        check(ta, "los_alarm", los_alarm, m_alarm);
        check(ts, "squelch", squelch, m_alarm | (!mode_e3 & lvl_below));
        check(rst_n ? "R7" : "R1", "clk_sel_ref", clk_sel_ref, m_alarm);
    endtask

    task automatic ds3_phase(int dens, int len, int below_pct);
        for (int i = 0; i < len; i++)
            step(($urandom % 100) < dens, ($urandom % 100) < below_pct, 1'b0, 1'b0);
    endtask

    task automatic e3_phase(int pb, int pa, int len);
        for (int i = 0; i < len; i++)
            step($urandom % 2, ($urandom % 100) < pb, ($urandom % 100) < pa, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        // R1: reset state.
        repeat (3) step(0, 0, 0, 0);
        rst_n = 1'b1;

        // R3: alternating bits clear the alarm after a full window.
        for (int i = 0; i < 30; i++) step(i % 2, 0, 0, 0);
        // R2: exact boundary, SZ-1 zeros hold, SZ-th zero sets.
        phase_tag = "R2";
        for (int i = 0; i < SZ - 1; i++) step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        for (int i = 0; i < SZ; i++) step(0, 0, 0, 0);
        // R9: long run keeps the alarm high without wrap.
        phase_tag = "R9";
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0);
        phase_tag = "";
        for (int i = 0; i < 30; i++) step(i % 2, 0, 0, 0);
        // R4: below flag squelches with the alarm low.
        for (int i = 0; i < 20; i++) step(i % 2, i % 3 == 0, 1, 0);
        // Random zero-density phases.
        for (int k = 0; k < 60; k++) begin
            int dl [5] = '{0, 3, 15, 35, 70};
            ds3_phase(dl[$urandom % 5], 5 + $urandom % 40, 10);
        end

        // R8: switch mode, alarm holds.
        step(0, 0, 0, 1);
        // R5: ES-1 below holds, ES-th sets.
        for (int i = 0; i < 12; i++) step(0, 0, 1, 1);
        for (int i = 0; i < ES - 1; i++) step(1, 1, 0, 1);
        step(1, 0, 0, 1);
        for (int i = 0; i < ES; i++) step(0, 1, 0, 1);
        // R6: EC-1 above holds, EC-th clears.
        for (int i = 0; i < EC - 1; i++) step(1, 0, 1, 1);
        step(1, 0, 0, 1);
        for (int i = 0; i < EC; i++) step(0, 0, 1, 1);
        // R9: long below run.
        phase_tag = "R9";
        for (int i = 0; i < 200; i++) step(1, 1, 0, 1);
        phase_tag = "";
        for (int k = 0; k < 60; k++) begin
            int sel = $urandom % 3;
            if (sel == 0) e3_phase(95, 0, 3 + $urandom % 20);
            else if (sel == 1) e3_phase(0, 95, 3 + $urandom % 20);
            else e3_phase(40, 40, 3 + $urandom % 20);
        end

        // R8: mixed mode toggles.
        for (int k = 0; k < 40; k++) begin
            if ($urandom % 2) ds3_phase(($urandom % 2) ? 50 : 0, 3 + $urandom % 30, 5);
            else e3_phase(($urandom % 2) ? 90 : 10, 50, 3 + $urandom % 15);
        end

        // R1: reset in mid-run.
        rst_n = 1'b0;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) step(i % 2, 0, 0, 0);
        report();
    end
endmodule